// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Registered Condition Flags

This block does the eight-bit arithmetic and logic work for a small accumulator-based processor core. Each cycle it takes an accumulator value, a second operand, an incoming carry and a three-bit operation code. It drives the eight-bit outcome combinationally on `result`. When the `op_valid` strobe is high, it captures a condition byte into a register on the rising clock edge. The supported operations are add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. Compare works out the flags of a subtraction but hands the accumulator back unchanged.

Each bit of the condition byte has a fixed position. A decoder elsewhere tests these bits by position, so the layout is part of the interface. Bits 5 and 3 have no meaning and always read zero. Bit 2 carries one of two meanings, chosen by the operation. After an arithmetic operation it holds signed overflow. After a logical operation it holds even parity.

Top module: `alu8_flags`

## Requirements
- R1: `op_sel` encodes 0=ADD, 1=ADC, 2=SUB, 3=SBC. For these four, `result` is the low 8 bits of A+B, A+B+cin, A-B and A-B-cin respectively. `carry_in` has no effect on ADD or SUB.
- R2: `op_sel` encodes 4=AND, 5=XOR, 6=OR. `result` is the bitwise AND, XOR or OR of A and B, and `carry_in` has no effect on them.
- R3: for `op_sel`=7 (CP), `result` equals `a_in`. The flags are those that SUB would give for the same A and B.
- R4: the flag byte is laid out from bit 7 down as S, Z, 0, H, 0, P/V, N, C. Bits 5 and 3 are always 0.
- R5: S is bit 7 and Z is the all-zero test of the 8-bit outcome. For CP, that outcome is the difference A-B.
- R6: for ADD and ADC, N=0. H is the carry out of bit 3, C is the carry out of bit 7, and P/V=1 when both operands share a sign that the sum does not have.
- R7: for SUB, SBC and CP, N=1. H is the borrow out of bit 3, C is the borrow out of bit 7, and P/V is signed subtraction overflow.
- R8: for the logical operations, N=0, C=0, and P/V=1 when the result has an even number of one bits. H=1 for AND and H=0 for XOR and OR.
- R9: `flags` loads on a rising edge only when `op_valid` is 1. Otherwise it holds its value, whatever the other inputs do.
- R10: when `rst_n` is 0 at a rising edge, `flags` becomes 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Strobe that loads the flag register |
| op_sel | input | 3 | Operation code |
| a_in | input | 8 | Accumulator operand |
| b_in | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry, used by ADC and SBC |
| result | output | 8 | Combinational outcome (A for CP) |
| flags | output | 8 | Registered condition byte |

## Verification
The two outputs are due at different times, and each check samples at the point where its output is due. `result` depends only on the present inputs. The bench checks it 1 ns after it drives the inputs, which is before the next rising edge. `flags` sits behind a single register, so its value for an operation is due just after the rising edge on which `op_valid` was high. The bench checks it 1 ns after that edge and changes nothing before the check. The hold check drives new operands with the strobe low and then confirms that the previously captured byte is still present one full edge later.

// File: rtl/alu8_pkg.sv
// Package alu8_pkg
// Shared operation codes and flag bit positions for the accumulator ALU.
// Assumes an 8-bit flag byte whose layout a downstream decoder relies on.
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5,
        OP_OR  = 3'd6,
        OP_CP  = 3'd7
    } alu_op_e;

    localparam int FLAG_W  = 8;
    localparam int FL_C    = 0;
    localparam int FL_N    = 1;
    localparam int FL_PV   = 2;
    localparam int FL_RSV3 = 3;
    localparam int FL_H    = 4;
    localparam int FL_RSV5 = 5;
    localparam int FL_Z    = 6;
    localparam int FL_S    = 7;

endpackage

// File: rtl/alu_addsub.sv
// Module alu_addsub
// Adder/subtractor split at the nibble boundary so that the nibble carry
// and the top carry come out directly. Subtraction is done as A + ~B + ~cin.
// Assumes DATA_W > NIB_W. Carries are raw adder carries; the consumer
// inverts them to get borrows when sub_mode is set.
module alu_addsub #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub_mode,
    output logic [DATA_W-1:0] sum,
    output logic              nib_carry,
    output logic              top_carry,
    output logic              ovf
);
    localparam int HI_W = DATA_W - NIB_W;

    logic [DATA_W-1:0] b_x;
    logic              c0;
    logic [NIB_W:0]    lo_sum;
    logic [HI_W:0]     hi_sum;

    // Pick the true or inverted operand and carry for add or subtract.
    always_comb begin
        b_x = sub_mode ? ~b : b;
        c0  = sub_mode ? ~cin : cin;
    end

    // Low nibble, then upper part chained on the nibble carry.
    always_comb begin
        lo_sum = {1'b0, a[NIB_W-1:0]} + {1'b0, b_x[NIB_W-1:0]}
               + {{NIB_W{1'b0}}, c0};
        hi_sum = {1'b0, a[DATA_W-1:NIB_W]} + {1'b0, b_x[DATA_W-1:NIB_W]}
               + {{HI_W{1'b0}}, lo_sum[NIB_W]};
    end

    // Assemble the sum and derive the carries and the signed overflow.
    always_comb begin
        sum       = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
        nib_carry = lo_sum[NIB_W];
        top_carry = hi_sum[HI_W];
        ovf       = (a[DATA_W-1] == b_x[DATA_W-1]) &&
                    (sum[DATA_W-1] != a[DATA_W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
// Module alu_logic
// Bitwise AND / XOR / OR unit with an even-parity output on its result.
// Assumes op only names a logical operation when this output is used.
module alu_logic #(
    parameter int DATA_W = 8
) (
    input  alu8_pkg::alu_op_e  op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    output logic [DATA_W-1:0]  res,
    output logic               par_even
);
    import alu8_pkg::*;

    // Select the bitwise function.
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            default: res = a | b;
        endcase
    end

    // Parity is even when the XOR reduction of the result is zero.
    always_comb par_even = ~^res;
endmodule

// File: rtl/alu_flag_gen.sv
// Module alu_flag_gen
// Chooses the outcome of the operation and assembles the next flag byte in
// the fixed S Z 0 H 0 P/V N C layout. The two unused bits are tied low.
// Assumes raw adder carries from alu_addsub; they are inverted to borrows here.
module alu_flag_gen #(
    parameter int DATA_W = 8
) (
    input  alu8_pkg::alu_op_e          op,
    input  logic                       sub_mode,
    input  logic [DATA_W-1:0]          a,
    input  logic [DATA_W-1:0]          as_sum,
    input  logic                       as_nib,
    input  logic                       as_top,
    input  logic                       as_ovf,
    input  logic [DATA_W-1:0]          lg_res,
    input  logic                       lg_par,
    output logic [DATA_W-1:0]          res_out,
    output logic [alu8_pkg::FLAG_W-1:0] flag_nxt
);
    import alu8_pkg::*;

    logic              is_logic;
    logic [DATA_W-1:0] outcome;

    // Classify the operation and pick the value the flags describe.
    always_comb begin
        is_logic = (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
        outcome  = is_logic ? lg_res : as_sum;
        res_out  = (op == OP_CP) ? a : outcome;
    end

    // Build the flag byte bit by bit.
    always_comb begin
        flag_nxt          = '0;
        flag_nxt[FL_S]    = outcome[DATA_W-1];
        flag_nxt[FL_Z]    = ~|outcome;
        flag_nxt[FL_H]    = is_logic ? (op == OP_AND) : (as_nib ^ sub_mode);
        flag_nxt[FL_PV]   = is_logic ? lg_par : as_ovf;
        flag_nxt[FL_N]    = sub_mode;
        flag_nxt[FL_C]    = is_logic ? 1'b0 : (as_top ^ sub_mode);
        flag_nxt[FL_RSV5] = 1'b0;
        flag_nxt[FL_RSV3] = 1'b0;
    end
endmodule

// File: rtl/alu8_flags.sv
// Module alu8_flags (top)
// Eight-bit accumulator ALU: combinational result, flag byte registered on
// op_valid. Synchronous active-low reset clears the flags.
// Assumes DATA_W = 8 for the flag layout (S taken from the top bit).
module alu8_flags #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic [7:0]        flags
);
    import alu8_pkg::*;

    alu_op_e           op;
    logic              sub_mode;
    logic              cin_eff;
    logic [DATA_W-1:0] as_sum;
    logic              as_nib;
    logic              as_top;
    logic              as_ovf;
    logic [DATA_W-1:0] lg_res;
    logic              lg_par;
    logic [FLAG_W-1:0] flag_nxt;

    // Decode the operation: subtract family and carry-in gating.
    always_comb begin
        op       = alu_op_e'(op_sel);
        sub_mode = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP);
        cin_eff  = carry_in && ((op == OP_ADC) || (op == OP_SBC));
    end

    alu_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
        .a        (a_in),
        .b        (b_in),
        .cin      (cin_eff),
        .sub_mode (sub_mode),
        .sum      (as_sum),
        .nib_carry(as_nib),
        .top_carry(as_top),
        .ovf      (as_ovf)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .op      (op),
        .a       (a_in),
        .b       (b_in),
        .res     (lg_res),
        .par_even(lg_par)
    );

    alu_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .op      (op),
        .sub_mode(sub_mode),
        .a       (a_in),
        .as_sum  (as_sum),
        .as_nib  (as_nib),
        .as_top  (as_top),
        .as_ovf  (as_ovf),
        .lg_res  (lg_res),
        .lg_par  (lg_par),
        .res_out (result),
        .flag_nxt(flag_nxt)
    );

    // Flag register: clear on reset, load on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        flags <= '0;
        else if (op_valid) flags <= flag_nxt;
    end
endmodule

// File: rtl/alu8_flags_chk.sv
// Module alu8_flags_chk
// Property checker for alu8_flags, attached by bind. Watches the ports only.
// Assumes DATA_W = 8.
module alu8_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [2:0] op_sel,
    input logic [7:0] a_in,
    input logic [7:0] b_in,
    input logic       carry_in,
    input logic [7:0] result,
    input logic [7:0] flags
);
    // R4
    rsvd_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flags[5] == 1'b0) && (flags[3] == 1'b0));

    // R3
    cp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd7) |-> (result == a_in));

    // R5
    sign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel != 3'd7) |=>
            (flags[7] == $past(result[7])) && (flags[6] == ($past(result) == 8'h00)));

    // R8
    logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel >= 3'd4 && op_sel <= 3'd6) |=>
            (flags[2] == ~^$past(result)) && (flags[1:0] == 2'b00));

    // R7
    sub_n_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == 3'd2 || op_sel == 3'd3 || op_sel == 3'd7)) |=> flags[1]);

    // R9
    hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (flags == 8'h00));

    // R2
    logic_carry_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 3'd4 && op_sel <= 3'd6 && b_in == 8'h00 && !carry_in) |->
            (op_sel == 3'd4 ? result == 8'h00 : result == a_in));
endmodule

bind alu8_flags alu8_flags_chk u_alu8_flags_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_valid(op_valid),
    .op_sel  (op_sel),
    .a_in    (a_in),
    .b_in    (b_in),
    .carry_in(carry_in),
    .result  (result),
    .flags   (flags)
);

// File: tb/test_alu8_flags.sv
`timescale 1ns/1ps
module test_alu8_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] a_in = 8'h00;
    logic [7:0] b_in = 8'h00;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic [7:0] flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    alu8_flags i_alu8_flags (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .a_in(a_in), .b_in(b_in), .carry_in(carry_in),
        .result(result), .flags(flags)
    );

    // Reference model: returns {result, flags} from the requirements.
    function automatic logic [15:0] model(int op, int a, int b, int c);
        int sa, sb, sr, r, out, h, v, n, cy, cc;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        h = 0; v = 0; n = 0; cy = 0; r = 0;
        if (op <= 1) begin
            cc = (op == 1) ? c : 0;
            r  = a + b + cc;
            h  = (((a % 16) + (b % 16) + cc) > 15) ? 1 : 0;
            sr = sa + sb + cc;
            v  = (sr > 127 || sr < -128) ? 1 : 0;
            cy = (r > 255) ? 1 : 0;
            r  = r % 256;
        end else if (op == 2 || op == 3 || op == 7) begin
            cc = (op == 3) ? c : 0;
            r  = a - b - cc;
            h  = (((a % 16) - (b % 16) - cc) < 0) ? 1 : 0;
            sr = sa - sb - cc;
            v  = (sr > 127 || sr < -128) ? 1 : 0;
            cy = (r < 0) ? 1 : 0;
            n  = 1;
            r  = (r + 256) % 256;
        end else begin
            int ones;
            if (op == 4) r = a & b;
            else if (op == 5) r = a ^ b;
            else r = a | b;
            h = (op == 4) ? 1 : 0;
            ones = 0;
            for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
            v = (ones % 2 == 0) ? 1 : 0;
        end
        out = (op == 7) ? a : r;
        model[15:8] = out[7:0];
        model[7:0]  = 8'(((r >> 7) & 1) << 7 | ((r == 0) ? 1 : 0) << 6 |
                         h << 4 | v << 2 | n << 1 | cy);
    endfunction

    function automatic int pick_b(int idx);
        case (idx)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h0F;
            4: return 8'h10;  5: return 8'h11;  6: return 8'h3F;  7: return 8'h40;
            8: return 8'h7E;  9: return 8'h7F; 10: return 8'h80; 11: return 8'h81;
            12: return 8'hC0; 13: return 8'hEF; 14: return 8'hF0; default: return 8'hFF;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string ctx);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, ctx, act, exp);
        end
    endtask

    // Drive one strobed vector, check result before the edge and flags after it.
    task automatic apply(int op, int a, int b, int c);
        logic [15:0] e;
        string rtag, ftag, ctx;
        e = model(op, a, b, c);
        @(negedge clk);
        op_sel = 3'(op); a_in = 8'(a); b_in = 8'(b); carry_in = c[0]; op_valid = 1'b1;
        #1;
        ctx = $sformatf("op=%0d a=%02h b=%02h c=%0d", op, a, b, c);
        rtag = (op <= 3) ? "R1" : (op == 7) ? "R3" : "R2";
        check(rtag, result, e[15:8], ctx);
        @(posedge clk);
        #1;
        ftag = (op <= 1) ? "R4 R5 R6" : (op <= 3) ? "R4 R5 R7" :
               (op == 7) ? "R3 R5 R7" : "R4 R5 R8";
        check(ftag, flags, e[7:0], ctx);
    endtask

    initial begin
        logic [7:0] held;
        // R10: flags clear under reset, even with the strobe high.
        op_valid = 1'b1; op_sel = 3'd2; a_in = 8'h00; b_in = 8'h01;
        repeat (3) @(posedge clk);
        #1;
        check("R10", flags, 8'h00, "during reset");
        @(negedge clk);
        rst_n = 1'b1; op_valid = 1'b0;

        // Near-exhaustive sweep: every op, every A, 16 B values, both carries.
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 256; a++)
                for (int bi = 0; bi < 16; bi++)
                    for (int c = 0; c < 2; c++)
                        apply(op, a, pick_b(bi), c);

        // R9: load known flags, then change inputs with the strobe low.
        apply(2, 8'h00, 8'h01, 0);           // flags = 0x93
        held = model(2, 0, 1, 0) & 16'h00FF;
        @(negedge clk);
        op_valid = 1'b0; op_sel = 3'd4; a_in = 8'h00; b_in = 8'h00;
        @(posedge clk); #1;
        check("R9", flags, held, "strobe low, 1 edge");
        @(posedge clk); #1;
        check("R9", flags, held, "strobe low, 2 edges");

        // R10: reset after activity clears the flags.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R10", flags, 8'h00, "reset after activity");
        @(negedge clk);
        rst_n = 1'b1;
        done = 1'b1;
    end

    // Summary and watchdog.
    initial begin
        fork
            wait (done);
            begin
                #(4 * 150000);
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule